// File: doc/BRIEF.md
# Three-Stage Load/Store Core with Exposed Delay Slots

This block is a small 16-bit load/store processor core built around a three-stage pipeline: a fetch stage, an operate stage that decodes and does the per-class work (register read and ALU operation, effective-address sum, or branch-target sum and condition test), and a final stage that commits the result (register write, data-memory transfer, or program-counter redirect). Separate instruction and data memory ports are provided. Both memories are expected to return read data combinationally within the cycle the address is presented.

No interlock or bypass logic exists. Any instruction's register result is only visible to the instruction two positions later in program order. A load therefore has a one-instruction delay slot. Every taken control transfer is followed by exactly two instructions that always execute before the target. Software fills these slots with useful work or NOPs. Once the pipeline is full, one instruction retires every clock.

Instructions are 16 bits wide: opcode in [15:12], destination/data register in [11:9], first source in [8:6], second source in [5:3], a signed 6-bit immediate in [5:0] and a signed 9-bit branch offset in [8:0]. There are eight registers, and register 0 is constant zero.

Top module: `rsc_core`

## Requirements
- R1: While rst_n is low, imem_addr is 0 and dmem_we is 0. After release, fetch starts at address 0 and the pipeline holds only NOPs, so no store occurs until a store instruction is fetched.
- R2: With no taken branch committing, imem_addr advances by exactly one every clock, so one instruction is fetched per cycle.
- R3: Register operations write rd = f(rs, rt) for opcode 1 ADD, 2 SUB (rs-rt), 3 AND, 4 OR, 5 XOR, and 6 SLT (1 if rs < rt as signed numbers, else 0). Opcode 7 ADDI writes rd = rs + sign-extended [5:0].
- R4: A register result is visible to the second following instruction. The instruction directly after the producer reads the previous value, because there is no write-through.
- R5: Opcode 8 LD writes rd = dmem[rs + sext([5:0])]. The directly following instruction still reads the old rd.
- R6: Opcode 9 ST writes the register named in [11:9] to dmem[rs + sext([5:0])]. dmem_we is high for exactly one cycle per store and is never asserted for any other opcode.
- R7: Opcode 12 BR jumps to (branch address + sext([8:0])). The two instructions after the branch execute, and the target is fetched in the cycle after the second of them, so the fetch addresses run b, b+1, b+2, target.
- R8: Opcode 10 BZ is taken when the register in [11:9] is zero, and opcode 11 BNZ when it is nonzero, each with the R7 timing and target. When not taken, fetch continues sequentially.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: Opcode 0 (NOP) and opcodes 13, 14 and 15 change no register and no memory location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| imem_addr | output | PC_W | Instruction word address (program counter) |
| imem_rdata | input | 16 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 16 | Data word address of the committing load/store |
| dmem_wdata | output | 16 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle per store |
| dmem_rdata | input | 16 | Data word at dmem_addr, same cycle |

## Verification
The assertions take for granted that reset is released away from a clock edge. They also assume that both memories answer combinationally, so whatever instruction word sits at imem_addr is latched by the operate stage at the next edge. The stimulus meets these assumptions with bench memories that read asynchronously from arrays indexed by the address ports, and by changing rst_n only at falling clock edges. Every program places NOPs or independent instructions in the load slot, in the result slot and in both branch slots wherever its expected values depend on them. The only exceptions are cases that deliberately read inside a slot to observe the old value.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  localparam int DATA_W = 16;
  localparam int INSN_W = 16;
  localparam int REG_N  = 8;
  localparam int REG_AW = $clog2(REG_N);
  localparam int OPC_W  = 4;
  localparam int IMM_W  = 6;
  localparam int OFF_W  = 9;

  // opcode values; 13..15 are unassigned and decode as no-ops
  localparam logic [OPC_W-1:0] OPC_NOP  = 4'd0;
  localparam logic [OPC_W-1:0] OPC_ADD  = 4'd1;
  localparam logic [OPC_W-1:0] OPC_SUB  = 4'd2;
  localparam logic [OPC_W-1:0] OPC_AND  = 4'd3;
  localparam logic [OPC_W-1:0] OPC_OR   = 4'd4;
  localparam logic [OPC_W-1:0] OPC_XOR  = 4'd5;
  localparam logic [OPC_W-1:0] OPC_SLT  = 4'd6;
  localparam logic [OPC_W-1:0] OPC_ADDI = 4'd7;
  localparam logic [OPC_W-1:0] OPC_LD   = 4'd8;
  localparam logic [OPC_W-1:0] OPC_ST   = 4'd9;
  localparam logic [OPC_W-1:0] OPC_BZ   = 4'd10;
  localparam logic [OPC_W-1:0] OPC_BNZ  = 4'd11;
  localparam logic [OPC_W-1:0] OPC_BR   = 4'd12;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_XOR,
    ALU_SLT
  } alu_e;

  // decoded control for the operate stage
  typedef struct packed {
    alu_e                alu;
    logic                use_imm;
    logic                wb;
    logic                ld;
    logic                st;
    logic                bz;
    logic                bnz;
    logic                br;
    logic [REG_AW-1:0]   rd;
    logic [REG_AW-1:0]   rs;
    logic [REG_AW-1:0]   rt;
    logic [DATA_W-1:0]   imm;
    logic [OFF_W-1:0]    off;
  } dec_t;

  // commit-stage pipeline register contents
  typedef struct packed {
    logic                wb;
    logic                ld;
    logic                st;
    logic [REG_AW-1:0]   rd;
    logic [DATA_W-1:0]   val;
    logic [DATA_W-1:0]   sdata;
  } cmt_t;

endpackage

// File: rtl/rsc_decode.sv
module rsc_decode
  import rsc_pkg::*;
(
  input  logic [INSN_W-1:0] ir,
  output dec_t              dec
);

  logic [OPC_W-1:0] opc;

  assign opc = ir[15:12];

  always_comb begin
    dec         = '0;
    dec.rd      = ir[11:9];
    dec.rs      = ir[8:6];
    dec.rt      = ir[5:3];
    dec.imm     = {{(DATA_W-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};
    dec.off     = ir[OFF_W-1:0];
    case (opc)
      OPC_ADD:  begin dec.alu = ALU_ADD; dec.wb = 1'b1; end
      OPC_SUB:  begin dec.alu = ALU_SUB; dec.wb = 1'b1; end
      OPC_AND:  begin dec.alu = ALU_AND; dec.wb = 1'b1; end
      OPC_OR:   begin dec.alu = ALU_OR;  dec.wb = 1'b1; end
      OPC_XOR:  begin dec.alu = ALU_XOR; dec.wb = 1'b1; end
      OPC_SLT:  begin dec.alu = ALU_SLT; dec.wb = 1'b1; end
      OPC_ADDI: begin dec.alu = ALU_ADD; dec.use_imm = 1'b1; dec.wb = 1'b1; end
      OPC_LD:   begin dec.alu = ALU_ADD; dec.use_imm = 1'b1; dec.ld = 1'b1; end
      OPC_ST:   begin dec.alu = ALU_ADD; dec.use_imm = 1'b1; dec.st = 1'b1; end
      OPC_BZ:   dec.bz  = 1'b1;
      OPC_BNZ:  dec.bnz = 1'b1;
      OPC_BR:   dec.br  = 1'b1;
      default:  ;
    endcase
  end

endmodule

// File: rtl/rsc_alu.sv
module rsc_alu
  import rsc_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_e          op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  logic lt;

  assign lt = $signed(a) < $signed(b);

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_SLT: y = {{(DW-1){1'b0}}, lt};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/rsc_regfile.sv
module rsc_regfile #(
  parameter int N  = 8,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] wa,
  input  logic [DW-1:0]        wd,
  input  logic [$clog2(N)-1:0] ra_a,
  input  logic [$clog2(N)-1:0] ra_b,
  input  logic [$clog2(N)-1:0] ra_c,
  output logic [DW-1:0]        rd_a,
  output logic [DW-1:0]        rd_b,
  output logic [DW-1:0]        rd_c
);

  localparam int AW = $clog2(N);

  logic [N*DW-1:0] flat;

  // entry 0 is hard-wired to zero and has no storage
  assign flat[DW-1:0] = '0;

  for (genvar g = 1; g < N; g++) begin : g_reg
    logic [DW-1:0] q;
    logic          en;

    assign en = we && (wa == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= wd;
      end
    end

    assign flat[g*DW +: DW] = q;
  end

  // plain array reads: a write in the same cycle is not forwarded
  assign rd_a = flat[ra_a*DW +: DW];
  assign rd_b = flat[ra_b*DW +: DW];
  assign rd_c = flat[ra_c*DW +: DW];

endmodule

// File: rtl/rsc_core.sv
module rsc_core
  import rsc_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PC_W-1:0]   imem_addr,
  input  logic [INSN_W-1:0] imem_rdata,
  output logic [DATA_W-1:0] dmem_addr,
  output logic [DATA_W-1:0] dmem_wdata,
  output logic              dmem_we,
  input  logic [DATA_W-1:0] dmem_rdata
);

  // ---------------- fetch stage state ----------------
  logic [PC_W-1:0]   pc_q, pc_d;

  // ---------------- operate stage state --------------
  logic [INSN_W-1:0] ir_a_q, ir_a_d;
  logic [PC_W-1:0]   pc_a_q, pc_a_d;

  // ---------------- commit stage state ---------------
  cmt_t              cm_q, cm_d;
  logic              e_redir, redir_d;
  logic [PC_W-1:0]   e_target, target_d;

  // ---------------- operate stage datapath -----------
  dec_t              dec;
  logic [DATA_W-1:0] rs_val, rt_val, rd_val;
  logic [DATA_W-1:0] alu_b, alu_y;
  logic [REG_AW-1:0] rs_idx;
  logic [OPC_W-1:0]  a_op;
  logic [PC_W-1:0]   off_pc;
  logic              rd_zero;
  logic              take;

  // ---------------- commit stage datapath ------------
  logic              rf_we;
  logic [DATA_W-1:0] rf_wd;

  rsc_decode u_dec (
    .ir  (ir_a_q),
    .dec (dec)
  );

  assign rs_idx = dec.rs;
  assign a_op   = ir_a_q[15:12];

  rsc_regfile #(
    .N  (REG_N),
    .DW (DATA_W)
  ) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .wa    (cm_q.rd),
    .wd    (rf_wd),
    .ra_a  (rs_idx),
    .ra_b  (dec.rt),
    .ra_c  (dec.rd),
    .rd_a  (rs_val),
    .rd_b  (rt_val),
    .rd_c  (rd_val)
  );

  assign alu_b = dec.use_imm ? dec.imm : rt_val;

  rsc_alu #(
    .DW (DATA_W)
  ) u_alu (
    .op (dec.alu),
    .a  (rs_val),
    .b  (alu_b),
    .y  (alu_y)
  );

  // branch target relative to the branch's own address
  assign off_pc  = {{(PC_W-OFF_W){dec.off[OFF_W-1]}}, dec.off};
  assign rd_zero = (rd_val == '0);
  assign take    = dec.br | (dec.bz & rd_zero) | (dec.bnz & ~rd_zero);

  // ---------------- next-state logic -----------------
  always_comb begin
    // fetch: redirect from the commit stage, else sequential
    pc_d      = e_redir ? e_target : pc_q + PC_W'(1);

    // operate stage captures the fetched word and its address
    ir_a_d    = imem_rdata;
    pc_a_d    = pc_q;

    // commit stage captures the operate stage's work
    cm_d.wb    = dec.wb;
    cm_d.ld    = dec.ld;
    cm_d.st    = dec.st;
    cm_d.rd    = dec.rd;
    cm_d.val   = alu_y;
    cm_d.sdata = rd_val;
    redir_d    = take;
    target_d   = pc_a_q + off_pc;
  end

  // ---------------- registers ------------------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      ir_a_q   <= '0;
      pc_a_q   <= '0;
      cm_q     <= '0;
      e_redir  <= 1'b0;
      e_target <= '0;
    end else begin
      pc_q     <= pc_d;
      ir_a_q   <= ir_a_d;
      pc_a_q   <= pc_a_d;
      cm_q     <= cm_d;
      e_redir  <= redir_d;
      e_target <= target_d;
    end
  end

  // ---------------- commit stage outputs -------------
  assign rf_we      = cm_q.wb | cm_q.ld;
  assign rf_wd      = cm_q.ld ? dmem_rdata : cm_q.val;

  assign imem_addr  = pc_q;
  assign dmem_addr  = cm_q.val;
  assign dmem_wdata = cm_q.sdata;
  assign dmem_we    = cm_q.st;

endmodule

// File: rtl/rsc_core_chk.sv
module rsc_core_chk
  import rsc_pkg::*;
#(
  parameter int PC_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   imem_addr,
  input logic              dmem_we,
  input logic [OPC_W-1:0]  a_op,
  input logic              e_redir,
  input logic [PC_W-1:0]   e_target,
  input logic [REG_AW-1:0] rs_idx,
  input logic [DATA_W-1:0] rs_val
);

  // set once a clock edge has passed outside reset, so $past is meaningful
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
    end
  end

  // R2: sequential fetch when nothing redirected
  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(e_redir)) |-> imem_addr == $past(imem_addr) + PC_W'(1));

  // R7: a committed branch sets the next fetch address to its target
  p_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(e_redir)) |-> imem_addr == $past(e_target));

  // R6: a store strobe is preceded by a store in the operate stage
  p_store_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && dmem_we) |-> $past(a_op) == OPC_ST);

  // R9: register 0 reads as zero
  p_zero_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_idx == '0) |-> rs_val == '0);

endmodule

bind rsc_core rsc_core_chk #(.PC_W(PC_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .imem_addr (imem_addr),
  .dmem_we   (dmem_we),
  .a_op      (a_op),
  .e_redir   (e_redir),
  .e_target  (e_target),
  .rs_idx    (rs_idx),
  .rs_val    (rs_val)
);

// File: tb/rsc_core_tb_top.sv
`timescale 1ns/1ps
module rsc_core_tb_top;

  logic        clk;
  logic        rst_n;
  logic [15:0] imem_addr;
  logic [15:0] imem_rdata;
  logic [15:0] dmem_addr;
  logic [15:0] dmem_wdata;
  logic        dmem_we;
  logic [15:0] dmem_rdata;

  logic [15:0] imem [256];
  logic [15:0] dmem [256];
  int          wr_cnt;
  int          n_chk;
  int          n_fail;
  bit          done;

  rsc_core #(.PC_W(16)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  assign imem_rdata = imem[imem_addr[7:0]];
  assign dmem_rdata = dmem[dmem_addr[7:0]];

  always @(posedge clk) begin
    if (rst_n && dmem_we) begin
      dmem[dmem_addr[7:0]] <= dmem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  // ---------------- encoders ----------------
  function automatic logic [15:0] e_rr(int op, int rd, int rs, int rt);
    return {op[3:0], rd[2:0], rs[2:0], rt[2:0], 3'b000};
  endfunction

  function automatic logic [15:0] e_ri(int op, int rd, int rs, int imm);
    return {op[3:0], rd[2:0], rs[2:0], imm[5:0]};
  endfunction

  function automatic logic [15:0] e_br(int op, int rd, int off);
    return {op[3:0], rd[2:0], off[8:0]};
  endfunction

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic start_prog();
    @(negedge clk);
    rst_n = 1'b0;
    wr_cnt = 0;
    for (int i = 0; i < 256; i++) begin
      imem[i] = 16'h0000;
      dmem[i] = 16'hA5A5;
    end
  endtask

  task automatic release_rst();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    start_prog();
    @(negedge clk);
    chk("R1 imem_addr in reset", imem_addr, 0);
    chk("R1 dmem_we in reset", dmem_we, 0);
    release_rst();
    for (int j = 0; j < 6; j++) begin
      chk("R2 sequential fetch", imem_addr, j);
      @(negedge clk);
    end
    chk("R1 no store from NOP fill", wr_cnt, 0);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset returns fetch to 0", imem_addr, 0);
    chk("R1 dmem_we low after reset", dmem_we, 0);
  endtask

  task automatic t_alu();
    start_prog();
    imem[0]  = e_ri(7, 1, 0, 5);
    imem[1]  = e_ri(7, 2, 0, -3);
    imem[3]  = e_rr(1, 3, 1, 2);
    imem[4]  = e_rr(2, 4, 1, 2);
    imem[5]  = e_rr(3, 5, 1, 2);
    imem[6]  = e_rr(4, 6, 1, 2);
    imem[7]  = e_rr(5, 7, 1, 2);
    imem[8]  = e_ri(9, 3, 0, 0);
    imem[9]  = e_ri(9, 4, 0, 1);
    imem[10] = e_ri(9, 5, 0, 2);
    imem[11] = e_ri(9, 6, 0, 3);
    imem[12] = e_ri(9, 7, 0, 4);
    imem[13] = e_rr(6, 3, 2, 1);
    imem[14] = e_rr(6, 4, 1, 2);
    imem[15] = e_ri(9, 3, 0, 5);
    imem[16] = e_ri(9, 4, 0, 6);
    release_rst();
    run(30);
    chk("R3 ADD", dmem[0], 16'h0002);
    chk("R3 SUB", dmem[1], 16'h0008);
    chk("R3 AND", dmem[2], 16'h0005);
    chk("R3 OR", dmem[3], 16'hFFFD);
    chk("R3 XOR", dmem[4], 16'hFFF8);
    chk("R3 SLT true", dmem[5], 16'h0001);
    chk("R3 SLT false", dmem[6], 16'h0000);
    chk("R6 one strobe per store", wr_cnt, 7);
  endtask

  task automatic t_slot_and_ignored();
    start_prog();
    imem[0]  = e_ri(7, 1, 0, 7);
    imem[2]  = e_ri(7, 1, 1, 1);
    imem[3]  = e_ri(9, 1, 0, 0);
    imem[4]  = e_ri(9, 1, 0, 1);
    imem[5]  = e_ri(7, 0, 0, 5);
    imem[7]  = e_ri(9, 0, 0, 2);
    imem[8]  = 16'hDFFF;
    imem[9]  = 16'hEFFF;
    imem[10] = 16'hFFFF;
    imem[12] = e_ri(9, 1, 0, 3);
    imem[13] = e_ri(9, 7, 0, 4);
    release_rst();
    run(25);
    chk("R4 next instr reads old value", dmem[0], 16'h0007);
    chk("R4 second instr reads new value", dmem[1], 16'h0008);
    chk("R9 write to r0 discarded", dmem[2], 16'h0000);
    chk("R10 reserved ops keep r1", dmem[3], 16'h0008);
    chk("R10 reserved ops keep r7", dmem[4], 16'h0000);
    chk("R10 no stray memory write", dmem[5], 16'hA5A5);
    chk("R6 store count", wr_cnt, 5);
  endtask

  task automatic t_load();
    start_prog();
    dmem[10] = 16'h1234;
    dmem[11] = 16'h0042;
    imem[0]  = e_ri(7, 1, 0, 10);
    imem[1]  = e_ri(7, 2, 0, 3);
    imem[2]  = e_ri(8, 2, 1, 0);
    imem[3]  = e_ri(9, 2, 0, 0);
    imem[4]  = e_ri(9, 2, 0, 1);
    imem[5]  = e_ri(8, 3, 1, 1);
    imem[6]  = e_rr(1, 4, 3, 3);
    imem[7]  = e_rr(1, 5, 3, 3);
    imem[9]  = e_ri(9, 4, 0, 2);
    imem[10] = e_ri(9, 5, 1, -1);
    release_rst();
    run(25);
    chk("R5 load slot sees old value", dmem[0], 16'h0003);
    chk("R5 loaded value after slot", dmem[1], 16'h1234);
    chk("R5 ALU in load slot uses old", dmem[2], 16'h0000);
    chk("R5 ALU after slot uses loaded", dmem[9], 16'h0084);
    chk("R6 negative offset address", wr_cnt, 4);
  endtask

  task automatic t_branch();
    start_prog();
    imem[0]  = e_ri(7, 1, 0, 1);
    imem[1]  = e_br(12, 0, 5);
    imem[2]  = e_ri(7, 2, 0, 2);
    imem[3]  = e_ri(7, 3, 0, 3);
    imem[4]  = e_ri(7, 4, 0, 4);
    imem[5]  = e_ri(7, 5, 0, 5);
    imem[6]  = e_ri(9, 1, 0, 0);
    imem[7]  = e_ri(9, 2, 0, 1);
    imem[8]  = e_ri(9, 3, 0, 2);
    imem[9]  = e_ri(9, 4, 0, 3);
    imem[10] = e_ri(9, 5, 0, 4);
    release_rst();
    begin
      int exp_seq [7] = '{0, 1, 2, 3, 6, 7, 8};
      for (int j = 0; j < 7; j++) begin
        chk("R7 fetch order around branch", imem_addr, exp_seq[j]);
        @(negedge clk);
      end
    end
    run(20);
    chk("R7 before branch", dmem[0], 16'h0001);
    chk("R7 first slot executes", dmem[1], 16'h0002);
    chk("R7 second slot executes", dmem[2], 16'h0003);
    chk("R7 skipped instr 4", dmem[3], 16'h0000);
    chk("R7 skipped instr 5", dmem[4], 16'h0000);
  endtask

  task automatic t_cond();
    start_prog();
    imem[0]  = e_ri(7, 1, 0, 3);
    imem[1]  = e_ri(7, 2, 0, 0);
    imem[3]  = e_ri(7, 2, 2, 2);
    imem[4]  = e_ri(7, 1, 1, -1);
    imem[6]  = e_br(11, 1, -3);
    imem[9]  = e_ri(9, 2, 0, 0);
    imem[10] = e_br(10, 1, 4);
    imem[11] = e_ri(7, 3, 0, 1);
    imem[12] = e_ri(7, 4, 0, 1);
    imem[13] = e_ri(7, 5, 0, 1);
    imem[14] = e_br(10, 2, 4);
    imem[15] = e_ri(7, 6, 0, 9);
    imem[16] = e_ri(7, 7, 0, 9);
    imem[17] = e_ri(7, 6, 6, 1);
    imem[18] = e_ri(9, 3, 0, 1);
    imem[19] = e_ri(9, 4, 0, 2);
    imem[20] = e_ri(9, 5, 0, 3);
    imem[21] = e_ri(9, 6, 0, 4);
    release_rst();
    run(80);
    chk("R8 BNZ loop ran three times", dmem[0], 16'h0006);
    chk("R8 BZ taken slot 1 executes", dmem[1], 16'h0001);
    chk("R8 BZ taken slot 2 executes", dmem[2], 16'h0001);
    chk("R8 BZ taken skips next", dmem[3], 16'h0000);
    chk("R8 BZ not taken falls through", dmem[4], 16'h000A);
    chk("R8 store count", wr_cnt, 5);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL all watchdog expired act=%0d exp=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- main ----------------
  initial begin
    n_chk  = 0;
    n_fail = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    wr_cnt = 0;
    for (int i = 0; i < 256; i++) begin
      imem[i] = 16'h0000;
      dmem[i] = 16'hA5A5;
    end
    t_reset();
    t_alu();
    t_slot_and_ignored();
    t_load();
    t_branch();
    t_cond();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule